// File: doc/BRIEF.md
# Per-Core Local Interrupt Register Window

This block holds a small set of interrupt registers for each of `N_CORES` cores. Each core has a control word, a local pending word, a local mask, a compare-interrupt route, an other-core pointer and a compare value. A core reaches these registers through two windows. The local window always lands on the core that issues the access, and the core's index arrives as a sideband field with the access. The other window lands on whichever core the requester's pointer register names, so one core can set up another core's local interrupts.

The block owns the local compare interrupt. A match pulse from the external counter sets a core's compare pending bit. Writing that core's compare-low register acknowledges the interrupt and hands the new compare value to the counter. For each core the block exports a compare request level and a one-hot set of interrupt pin lines that the request drives. Reads return data one cycle after the request, flagged by `rdValid`.

Register selects on `regOfs`: 0 control, 1 pending, 2 mask, 3 mask-clear, 4 mask-set, 5 compare map, 6 other pointer, 7 identity, 8 compare-low, 9 compare-high. The pending and mask words use bit 1 for the compare interrupt. In the compare map, bit 31 is the route flag and bits [5:0] are the pin field.

Top module: `core_local_irq_window`

## Requirements
- R1: After reset each core reads control 0, pending 0, mask 0x32, compare map 0x8000_0000, other pointer 0 and compare-low 0xFFFF_FFFF, and no request or pin line is active.
- R2: A local-window access (`regOther`=0) targets core `regCore`. The identity register (select 7) reads the targeted core's index. Read data appears with `rdValid` in the cycle after the request.
- R3: An other-window access (`regOther`=1) targets the core held in the requester's other pointer (select 6), for both reads and writes.
- R4: A write to the other pointer with a value of `N_CORES` or more leaves the pointer unchanged.
- R5: The mask (select 2, read-only) changes only through select 4, where each 1 bit sets the matching bit of the 6-bit mask, and select 3, where each 1 bit clears it.
- R6: A compare-map write whose bits [5:0] exceed `MAX_PIN` is dropped. An accepted write keeps only bit 31 and the pin field, and every other bit reads back as zero.
- R7: A `timerHit` pulse sets the core's compare pending bit (bit 1 of select 1). The core's request and the pin line named by its map are high exactly while pending, mask bit 1 and the route flag are all set.
- R8: A compare-low write (select 8) clears the core's compare pending bit and stores the value. In the next cycle it presents `cmpFwdValid` with the core and the value for the counter.
- R9: Writes to control (select 0) and compare-high (select 9) have no effect. Compare-high, the mask-set and mask-clear selects, and unused selects read 0.
- R10: When a match pulse and a compare-low write reach the same core in one cycle, the pending bit ends set.
- R11: With the route flag cleared, a pending and unmasked compare raises neither the request nor any pin line, and the pending bit stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regOther | input | 1 | 0 = local window, 1 = other window |
| regOfs | input | 4 | Register select |
| regCore | input | CORE_W | Index of the requesting core |
| regWdata | input | 32 | Write data |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| timerHit | input | N_CORES | Per-core compare match pulse |
| cmpReq | output | N_CORES | Per-core compare interrupt request |
| pinLines | output | N_CORES*NUM_PINS | Per-core one-hot pin lines, core c at [c*NUM_PINS +: NUM_PINS] |
| cmpFwdValid | output | 1 | New compare value for the counter |
| cmpFwdCore | output | CORE_W | Core owning the forwarded value |
| cmpFwdValue | output | 32 | Forwarded compare value |

## Verification
The assertions take for granted that `regCore` and every stored other pointer name an existing core, that inputs carry no unknown values while out of reset, and that at most one register access arrives per cycle. The stimulus drives one access at a time from a single task at the falling edge, using only core indices below `N_CORES`. It aims `timerHit` pulses at chosen cores, and only in the simultaneous case does a pulse fall in the same cycle as a compare-low write to that core. Read results go into an expected-value queue, and a monitor drains that queue on `rdValid`.

// File: rtl/clw_pkg.sv
package clw_pkg;
  localparam int OFS_W      = 4;
  localparam int DATA_W     = 32;
  localparam int MASK_W     = 6;
  localparam int CMP_BIT    = 1;
  localparam int ROUTE_BIT  = 31;
  localparam int PINF_W     = 6;
  localparam logic [MASK_W-1:0] MASK_RST = 6'h32;

  typedef enum logic [OFS_W-1:0] {
    SelCtrl    = 4'd0,
    SelPend    = 4'd1,
    SelMask    = 4'd2,
    SelMaskClr = 4'd3,
    SelMaskSet = 4'd4,
    SelCmpMap  = 4'd5,
    SelOther   = 4'd6,
    SelIdent   = 4'd7,
    SelCmpLo   = 4'd8,
    SelCmpHi   = 4'd9
  } regSel_e;

  typedef struct packed {
    logic wrMaskSet;
    logic wrMaskClr;
    logic wrMap;
    logic wrOther;
    logic wrCmp;
    logic rdEn;
  } strobe_t;
endpackage

// File: rtl/clw_ctrl.sv
module clw_ctrl
  import clw_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int MAX_PIN = 5,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                           regValid,
  input  logic                           regWrite,
  input  logic                           regOther,
  input  logic [OFS_W-1:0]               regOfs,
  input  logic [CORE_W-1:0]              regCore,
  input  logic [DATA_W-1:0]              regWdata,
  input  logic [N_CORES-1:0][CORE_W-1:0] otherVec,
  output strobe_t                        strb,
  output logic [CORE_W-1:0]              tgtCore
);
  logic isWr;
  logic otherOk;
  logic pinOk;

  // The other window follows the requester's pointer.
  assign tgtCore = regOther ? otherVec[regCore] : regCore;
  assign isWr    = regValid && regWrite;
  assign otherOk = regWdata < DATA_W'(N_CORES);
  assign pinOk   = regWdata[PINF_W-1:0] <= PINF_W'(MAX_PIN);

  always_comb begin
    strb           = '0;
    strb.rdEn      = regValid && !regWrite;
    strb.wrMaskSet = isWr && (regOfs == SelMaskSet);
    strb.wrMaskClr = isWr && (regOfs == SelMaskClr);
    strb.wrMap     = isWr && (regOfs == SelCmpMap) && pinOk;
    strb.wrOther   = isWr && (regOfs == SelOther) && otherOk;
    strb.wrCmp     = isWr && (regOfs == SelCmpLo);
  end
endmodule

// File: rtl/clw_datapath.sv
module clw_datapath
  import clw_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int MAX_PIN = 5,
  localparam int CORE_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int NUM_PINS = MAX_PIN + 1,
  localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          strb,
  input  logic [CORE_W-1:0]                tgtCore,
  input  logic [OFS_W-1:0]                 regOfs,
  input  logic [DATA_W-1:0]                regWdata,
  input  logic [N_CORES-1:0]               timerHit,
  output logic [N_CORES-1:0][CORE_W-1:0]   otherVec,
  output logic                             rdValid,
  output logic [DATA_W-1:0]                rdData,
  output logic [N_CORES-1:0]               cmpReq,
  output logic [N_CORES-1:0][NUM_PINS-1:0] pinVec,
  output logic                             cmpFwdValid,
  output logic [CORE_W-1:0]                cmpFwdCore,
  output logic [DATA_W-1:0]                cmpFwdValue
);
  logic [N_CORES-1:0][MASK_W-1:0] maskVec;
  logic [N_CORES-1:0]             pendVec;
  logic [N_CORES-1:0]             routeVec;
  logic [N_CORES-1:0][PIN_W-1:0]  pinSelVec;
  logic [N_CORES-1:0][DATA_W-1:0] cmpVec;
  logic [DATA_W-1:0]              rdMux;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic              sel;
    logic [MASK_W-1:0] maskQ;
    logic              pendQ;
    logic              routeQ;
    logic [PIN_W-1:0]  pinQ;
    logic [CORE_W-1:0] otherQ;
    logic [DATA_W-1:0] cmpQ;

    assign sel = (tgtCore == CORE_W'(c));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ  <= MASK_RST;
        pendQ  <= 1'b0;
        routeQ <= 1'b1;
        pinQ   <= '0;
        otherQ <= '0;
        cmpQ   <= '1;
      end else begin
        if (sel && strb.wrMaskSet) maskQ <= maskQ | regWdata[MASK_W-1:0];
        if (sel && strb.wrMaskClr) maskQ <= maskQ & ~regWdata[MASK_W-1:0];
        if (sel && strb.wrMap) begin
          routeQ <= regWdata[ROUTE_BIT];
          pinQ   <= regWdata[PIN_W-1:0];
        end
        if (sel && strb.wrOther) otherQ <= regWdata[CORE_W-1:0];
        if (sel && strb.wrCmp) begin
          cmpQ  <= regWdata;
          pendQ <= 1'b0;
        end
        // A match in the same cycle as an acknowledge wins.
        if (timerHit[c]) pendQ <= 1'b1;
      end
    end

    assign maskVec[c]   = maskQ;
    assign pendVec[c]   = pendQ;
    assign routeVec[c]  = routeQ;
    assign pinSelVec[c] = pinQ;
    assign otherVec[c]  = otherQ;
    assign cmpVec[c]    = cmpQ;
    assign cmpReq[c]    = pendQ && maskQ[CMP_BIT] && routeQ;
    assign pinVec[c]    = cmpReq[c] ? (NUM_PINS'(1) << pinQ) : '0;
  end

  always_comb begin
    rdMux = '0;
    case (regOfs)
      SelPend:   rdMux[CMP_BIT] = pendVec[tgtCore];
      SelMask:   rdMux[MASK_W-1:0] = maskVec[tgtCore];
      SelCmpMap: begin
        rdMux[ROUTE_BIT]   = routeVec[tgtCore];
        rdMux[PIN_W-1:0]   = pinSelVec[tgtCore];
      end
      SelOther:  rdMux[CORE_W-1:0] = otherVec[tgtCore];
      SelIdent:  rdMux[CORE_W-1:0] = tgtCore;
      SelCmpLo:  rdMux = cmpVec[tgtCore];
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid     <= 1'b0;
      rdData      <= '0;
      cmpFwdValid <= 1'b0;
      cmpFwdCore  <= '0;
      cmpFwdValue <= '0;
    end else begin
      rdValid     <= strb.rdEn;
      if (strb.rdEn) rdData <= rdMux;
      cmpFwdValid <= strb.wrCmp;
      if (strb.wrCmp) begin
        cmpFwdCore  <= tgtCore;
        cmpFwdValue <= regWdata;
      end
    end
  end
endmodule

// File: rtl/core_local_irq_window.sv
module core_local_irq_window
  import clw_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int MAX_PIN = 5,
  localparam int CORE_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int NUM_PINS = MAX_PIN + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regValid,
  input  logic                          regWrite,
  input  logic                          regOther,
  input  logic [3:0]                    regOfs,
  input  logic [CORE_W-1:0]             regCore,
  input  logic [31:0]                   regWdata,
  output logic                          rdValid,
  output logic [31:0]                   rdData,
  input  logic [N_CORES-1:0]            timerHit,
  output logic [N_CORES-1:0]            cmpReq,
  output logic [N_CORES*NUM_PINS-1:0]   pinLines,
  output logic                          cmpFwdValid,
  output logic [CORE_W-1:0]             cmpFwdCore,
  output logic [31:0]                   cmpFwdValue
);
  strobe_t                          strb;
  logic [CORE_W-1:0]                tgtCore;
  logic [N_CORES-1:0][CORE_W-1:0]   otherVec;
  logic [N_CORES-1:0][NUM_PINS-1:0] pinVec;

  clw_ctrl #(.N_CORES(N_CORES), .MAX_PIN(MAX_PIN)) ctrl_i (
    .regValid(regValid), .regWrite(regWrite), .regOther(regOther),
    .regOfs(regOfs), .regCore(regCore), .regWdata(regWdata),
    .otherVec(otherVec), .strb(strb), .tgtCore(tgtCore)
  );

  clw_datapath #(.N_CORES(N_CORES), .MAX_PIN(MAX_PIN)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .tgtCore(tgtCore),
    .regOfs(regOfs), .regWdata(regWdata), .timerHit(timerHit),
    .otherVec(otherVec), .rdValid(rdValid), .rdData(rdData),
    .cmpReq(cmpReq), .pinVec(pinVec), .cmpFwdValid(cmpFwdValid),
    .cmpFwdCore(cmpFwdCore), .cmpFwdValue(cmpFwdValue)
  );

  assign pinLines = pinVec;
endmodule

// File: rtl/clw_checker.sv
module clw_checker #(
  parameter int N_CORES = 4,
  parameter int MAX_PIN = 5,
  localparam int CORE_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int NUM_PINS = MAX_PIN + 1
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        regValid,
  input logic                        regWrite,
  input logic [3:0]                  regOfs,
  input logic                        rdValid,
  input logic [N_CORES-1:0]          timerHit,
  input logic [N_CORES-1:0]          cmpReq,
  input logic [N_CORES*NUM_PINS-1:0] pinLines,
  input logic                        cmpFwdValid,
  input logic [CORE_W-1:0]           cmpFwdCore
);
  logic [N_CORES-1:0] hitPrev;
  always_ff @(posedge clk) begin
    if (!rstN) hitPrev <= '0;
    else       hitPrev <= timerHit;
  end

  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(regValid && !regWrite));

  p_fwd_from_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmpFwdValid |-> $past(regValid && regWrite && regOfs == 4'd8));

  p_ack_drops_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmpFwdValid && !hitPrev[cmpFwdCore]) |-> !cmpReq[cmpFwdCore]);

  for (genvar c = 0; c < N_CORES; c++) begin : g_chk
    p_pin_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(pinLines[c*NUM_PINS +: NUM_PINS]));

    p_pin_tracks_req_r7: assert property (@(posedge clk) disable iff (!rstN)
      (|pinLines[c*NUM_PINS +: NUM_PINS]) == cmpReq[c]);

    p_req_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(cmpReq[c]) |-> ($past(timerHit[c]) || $past(regValid && regWrite)));
  end
endmodule

bind core_local_irq_window clw_checker #(.N_CORES(N_CORES), .MAX_PIN(MAX_PIN)) chk_i (
  .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
  .regOfs(regOfs), .rdValid(rdValid), .timerHit(timerHit), .cmpReq(cmpReq),
  .pinLines(pinLines), .cmpFwdValid(cmpFwdValid), .cmpFwdCore(cmpFwdCore)
);

// File: tb/core_local_irq_window_tb_top.sv
module core_local_irq_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_CORES    = 4;
  localparam int MAX_PIN    = 5;
  localparam int CORE_W     = 2;
  localparam int NUM_PINS   = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regValid = 1'b0, regWrite = 1'b0, regOther = 1'b0;
  logic [3:0] regOfs = '0;
  logic [CORE_W-1:0] regCore = '0;
  logic [31:0] regWdata = '0;
  logic rdValid;
  logic [31:0] rdData;
  logic [N_CORES-1:0] timerHit = '0;
  logic [N_CORES-1:0] cmpReq;
  logic [N_CORES*NUM_PINS-1:0] pinLines;
  logic cmpFwdValid;
  logic [CORE_W-1:0] cmpFwdCore;
  logic [31:0] cmpFwdValue;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  core_local_irq_window #(.N_CORES(N_CORES), .MAX_PIN(MAX_PIN)) dut_i (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regOther(regOther), .regOfs(regOfs), .regCore(regCore),
    .regWdata(regWdata), .rdValid(rdValid), .rdData(rdData),
    .timerHit(timerHit), .cmpReq(cmpReq), .pinLines(pinLines),
    .cmpFwdValid(cmpFwdValid), .cmpFwdCore(cmpFwdCore),
    .cmpFwdValue(cmpFwdValue)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Driver: one access per call, with optional match pulses in the same cycle.
  task automatic access(input bit wr, input bit oth, input int core, input int ofs,
                        input logic [31:0] data, input logic [N_CORES-1:0] hit);
    @(negedge clk);
    regValid = 1'b1; regWrite = wr; regOther = oth;
    regCore = CORE_W'(core); regOfs = 4'(ofs); regWdata = data; timerHit = hit;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0; regOther = 1'b0; timerHit = '0;
  endtask

  task automatic wr(input int core, input bit oth, input int ofs, input logic [31:0] d);
    access(1'b1, oth, core, ofs, d, '0);
  endtask

  task automatic rd(input int core, input bit oth, input int ofs,
                    input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    access(1'b0, oth, core, ofs, 32'h0, '0);
  endtask

  task automatic pulse(input logic [N_CORES-1:0] hit);
    @(negedge clk);
    timerHit = hit;
    @(negedge clk);
    timerHit = '0;
  endtask

  // Monitor: pops the scoreboard whenever read data comes back.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected rdValid", 32'h1, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData === e, t, rdData, e);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmpReq == 0, "R1 cmpReq", 32'(cmpReq), 0);
    check(pinLines == 0, "R1 pinLines", 32'(pinLines), 0);
    check(cmpFwdValid == 0, "R1 cmpFwdValid", 32'(cmpFwdValid), 0);
    rd(0, 0, 0, 32'h0, "R1 ctrl");
    rd(0, 0, 1, 32'h0, "R1 pend");
    rd(0, 0, 2, 32'h32, "R1 mask");
    rd(3, 0, 5, 32'h8000_0000, "R1 map");
    rd(3, 0, 6, 32'h0, "R1 other");
    rd(3, 0, 8, 32'hFFFF_FFFF, "R1 cmplo");
    rd(0, 0, 9, 32'h0, "R9 cmphi");
    // R2 local identity
    rd(3, 0, 7, 32'h3, "R2 ident core3");
    rd(1, 0, 7, 32'h1, "R2 ident core1");
    // R5 mask set/clear
    wr(1, 0, 3, 32'hFFFF_FF12);
    rd(1, 0, 2, 32'h20, "R5 mask clear");
    wr(1, 0, 4, 32'h0000_0005);
    rd(1, 0, 2, 32'h25, "R5 mask set");
    rd(0, 0, 2, 32'h32, "R2 other core mask untouched");
    // R4 pointer range
    wr(0, 0, 6, 32'd5);
    rd(0, 0, 6, 32'h0, "R4 other=5 ignored");
    wr(0, 0, 6, 32'd4);
    rd(0, 0, 6, 32'h0, "R4 other=4 ignored");
    wr(0, 0, 6, 32'd2);
    rd(0, 0, 6, 32'h2, "R4 other=2 accepted");
    // R3 other window
    rd(0, 1, 7, 32'h2, "R3 ident via other");
    wr(0, 1, 4, 32'h08);
    rd(2, 0, 2, 32'h3A, "R3 mask set via other");
    rd(0, 0, 2, 32'h32, "R3 requester mask untouched");
    rd(0, 1, 6, 32'h0, "R3 other ptr of target");
    // R6 compare map
    wr(2, 0, 5, 32'h0000_0006);
    rd(2, 0, 5, 32'h8000_0000, "R6 pin 6 rejected");
    wr(2, 0, 5, 32'hFFFF_FFC3);
    rd(2, 0, 5, 32'h8000_0003, "R6 accepted fields only");
    // R7 match sets pending and drives pin 3 of core 2
    pulse(4'b0100);
    check(cmpReq == 4'b0100, "R7 cmpReq core2", 32'(cmpReq), 32'h4);
    check(pinLines[2*NUM_PINS +: NUM_PINS] == 6'b001000, "R7 pin3 core2",
          32'(pinLines[2*NUM_PINS +: NUM_PINS]), 32'h8);
    rd(2, 0, 1, 32'h2, "R7 pend core2");
    // R7 masked core1 (mask 0x25, bit1 clear)
    pulse(4'b0010);
    check(cmpReq[1] == 1'b0, "R7 masked core1", 32'(cmpReq[1]), 0);
    rd(1, 0, 1, 32'h2, "R7 masked core1 pend");
    // R8 acknowledge via compare-low
    wr(2, 0, 8, 32'h0000_1234);
    check(cmpFwdValid == 1'b1, "R8 fwd valid", 32'(cmpFwdValid), 1);
    check(cmpFwdCore == 2'd2, "R8 fwd core", 32'(cmpFwdCore), 2);
    check(cmpFwdValue == 32'h1234, "R8 fwd value", cmpFwdValue, 32'h1234);
    check(cmpReq[2] == 1'b0, "R8 req cleared", 32'(cmpReq[2]), 0);
    rd(2, 0, 1, 32'h0, "R8 pend cleared");
    rd(2, 0, 8, 32'h1234, "R8 cmplo stored");
    // R11 route flag
    pulse(4'b1000);
    check(pinLines[3*NUM_PINS +: NUM_PINS] == 6'b000001, "R7 core3 pin0",
          32'(pinLines[3*NUM_PINS +: NUM_PINS]), 32'h1);
    wr(3, 0, 5, 32'h0000_0004);
    check(cmpReq[3] == 1'b0, "R11 unrouted req", 32'(cmpReq[3]), 0);
    check(pinLines[3*NUM_PINS +: NUM_PINS] == 0, "R11 unrouted pins",
          32'(pinLines[3*NUM_PINS +: NUM_PINS]), 0);
    rd(3, 0, 1, 32'h2, "R11 pend kept");
    // R10 match and acknowledge together
    access(1'b1, 1'b0, 2, 8, 32'h55, 4'b0100);
    check(cmpReq[2] == 1'b1, "R10 match wins", 32'(cmpReq[2]), 1);
    rd(2, 0, 1, 32'h2, "R10 pend set");
    // R9 ignored writes
    wr(0, 0, 0, 32'hFFFF_FFFF);
    rd(0, 0, 0, 32'h0, "R9 ctrl write ignored");
    wr(2, 0, 9, 32'hFFFF_FFFF);
    rd(2, 0, 9, 32'h0, "R9 cmphi reads 0");
    rd(2, 0, 8, 32'h55, "R9 cmphi write no effect on cmplo");
    rd(2, 0, 4, 32'h0, "R9 mask-set select reads 0");
    rd(2, 0, 12, 32'h0, "R9 unused select reads 0");
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 all reads returned", 32'(expQ.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule